// File: doc/BRIEF.md
# JTAG Instruction and Data Register Unit

This block holds the instruction register of a boundary-scan test port and the data registers it selects between TDI and TDO. A TAP state machine outside the block supplies one strobe per controller state (Test-Logic-Reset, Capture/Shift/Update for the instruction path and for the data path) together with TCK and TDI. The block decodes the current instruction to pick one of four data registers:

- a 32-bit identification word;
- a parameterised boundary chain with its output latches;
- a one-bit device-reset cell;
- a one-bit bypass cell.

It drives TDO, a device reset request and the boundary output latches. The latches are brought out only as a port and are never routed to pads. The reset cell feeds the reset request directly, with no update stage, so the request follows the cell from the shift edge onward. Loading another instruction leaves the reset cell untouched. Only Test-Logic-Reset clears it.

Top module: `jtag_dr_unit`

## Requirements
- R1: While `tlr` is high at a rising TCK edge, the block returns to its reset state: instruction 4'h1 (identification), `tdo` low, `sys_rst_req` low, and all `bsr_latch` bits low.
- R2: With instruction 4'h1 selected, Capture-DR loads the identification word. Bits 31:28 hold the version, 27:12 the part number and 11:1 the manufacturer code, and bit 0 is 1. With the defaults the word is 32'h35A3_C56B.
- R3: Every shift path moves toward TDO, with bit 0 first, on the rising TCK edge. `tdo` updates on the falling edge to bit 0 of the path being shifted, and it is low when neither shift strobe is high.
- R4: Capture-IR loads 4'b0001 into the instruction shift path. The active instruction changes only at Update-IR, to the 4 bits that were shifted in.
- R5: Instruction 4'hF selects the bypass cell. Capture-DR loads 0 into it, and Shift-DR delays TDI by exactly one cell.
- R6: Instruction 4'h2 selects the boundary chain. Capture-DR loads `pin_in`, Shift-DR shifts the chain, and Update-DR copies the chain into `bsr_latch`.
- R7: `bsr_latch` changes only at Update-DR while instruction 4'h2 is active.
- R8: Instruction 4'hC selects the one-bit reset cell, which only Shift-DR alters. `sys_rst_req` equals the cell directly after the shift edge, and Capture-DR and Update-DR leave it unchanged.
- R9: The reset cell and `sys_rst_req` keep their value while other instructions are loaded and used. An asserted request does not disturb instruction loading or the other data registers.
- R10: Test-Logic-Reset clears the reset cell, which releases `sys_rst_req`.
- R11: Any instruction code other than 4'h1, 4'h2 and 4'hC behaves as bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr | input | 1 | TAP is in Test-Logic-Reset (synchronous, active high) |
| cap_ir | input | 1 | TAP is in Capture-IR |
| shift_ir | input | 1 | TAP is in Shift-IR |
| upd_ir | input | 1 | TAP is in Update-IR |
| cap_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| upd_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial test data in |
| pin_in | input | BSR_LEN | Pin values sampled by the boundary chain |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| sys_rst_req | output | 1 | Device reset request taken straight from the reset cell |
| bsr_latch | output | BSR_LEN | Boundary update latches, not connected to pins |

## Verification
Register contents, `sys_rst_req` and `bsr_latch` change at the rising TCK edge that ends the state carrying a strobe. `tdo` changes at the falling edge inside a shift state, from the value the path held after the previous rising edge. The bench drives strobes 1 ns after each rising edge and compares every output 1 ns after the falling edge against a queue-based model. At that point the model still holds its state from the last rising edge, and it applies the new strobes only after the comparison. As a result, `tdo` is checked in the same cycle as its shift strobe, and register effects are checked one cycle after their strobe, which matches the one register stage each of them passes through.

// File: rtl/jtag_dr_pkg.sv
package jtag_dr_pkg;

    localparam int IR_W = 4;
    localparam int ID_W = 32;

    typedef enum logic [IR_W-1:0] {
        INS_IDCODE = 4'h1,
        INS_SAMPLE = 4'h2,
        INS_RESET  = 4'hC,
        INS_BYPASS = 4'hF
    } instr_e;

    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [1:0] {
        DR_ID,
        DR_BOUNDARY,
        DR_RSTCELL,
        DR_BYPASS
    } dr_sel_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } scan_ctl_t;

    // Unknown codes fall back to the bypass cell.
    function automatic dr_sel_e decode_instr(input logic [IR_W-1:0] code);
        case (code)
            INS_IDCODE: return DR_ID;
            INS_SAMPLE: return DR_BOUNDARY;
            INS_RESET:  return DR_RSTCELL;
            default:    return DR_BYPASS;
        endcase
    endfunction

    function automatic logic [ID_W-1:0] make_idcode(input logic [3:0]  ver,
                                                    input logic [15:0] part,
                                                    input logic [10:0] mfr);
        return {ver, part, mfr, 1'b1};
    endfunction

endpackage

// File: rtl/jtag_ir_unit.sv
module jtag_ir_unit
    import jtag_dr_pkg::*;
(
    input  logic             tck,
    input  logic             tlr,
    input  logic             tdi,
    input  scan_ctl_t        ctl,
    output logic             ir_so,
    output logic [IR_W-1:0]  ir_code
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck) begin
        if (tlr) begin
            ir_sr   <= IR_CAPTURE;
            ir_code <= INS_IDCODE;
        end else begin
            if (ctl.capture)
                ir_sr <= IR_CAPTURE;
            else if (ctl.shift)
                ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            if (ctl.update)
                ir_code <= ir_sr;
        end
    end

    assign ir_so = ir_sr[0];

endmodule

// File: rtl/jtag_pload_sr.sv
module jtag_pload_sr #(
    parameter int W = 8
) (
    input  logic         tck,
    input  logic         tlr,
    input  logic         tdi,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] pdata,
    output logic         so
);

    logic [W-1:0] q;
    logic [W-1:0] q_shifted;

    generate
        if (W == 1) begin : g_single
            assign q_shifted = tdi;
        end else begin : g_multi
            assign q_shifted = {tdi, q[W-1:1]};
        end
    endgenerate

    always_ff @(posedge tck) begin
        if (tlr)
            q <= '0;
        else if (load)
            q <= pdata;
        else if (shift)
            q <= q_shifted;
    end

    assign so = q[0];

endmodule

// File: rtl/jtag_bscan_chain.sv
module jtag_bscan_chain
    import jtag_dr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         tck,
    input  logic         tlr,
    input  logic         tdi,
    input  scan_ctl_t    ctl,
    input  logic [N-1:0] pin_in,
    output logic         chain_so,
    output logic [N-1:0] latch_q
);

    logic [N-1:0] cells;
    logic [N-1:0] cell_in;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_cell
            if (i == N - 1) begin : g_head
                assign cell_in[i] = tdi;
            end else begin : g_link
                assign cell_in[i] = cells[i+1];
            end
        end
    endgenerate

    always_ff @(posedge tck) begin
        if (tlr)
            cells <= '0;
        else if (ctl.capture)
            cells <= pin_in;
        else if (ctl.shift)
            cells <= cell_in;
    end

    always_ff @(posedge tck) begin
        if (tlr)
            latch_q <= '0;
        else if (ctl.update)
            latch_q <= cells;
    end

    assign chain_so = cells[0];

endmodule

// File: rtl/jtag_dr_unit.sv
module jtag_dr_unit
    import jtag_dr_pkg::*;
#(
    parameter int          BSR_LEN    = 8,
    parameter logic [3:0]  ID_VERSION = 4'h3,
    parameter logic [15:0] ID_PART    = 16'h5A3C,
    parameter logic [10:0] ID_MFR     = 11'h2B5
) (
    input  logic               tck,
    input  logic               tlr,
    input  logic               cap_ir,
    input  logic               shift_ir,
    input  logic               upd_ir,
    input  logic               cap_dr,
    input  logic               shift_dr,
    input  logic               upd_dr,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               tdo,
    output logic               sys_rst_req,
    output logic [BSR_LEN-1:0] bsr_latch
);

    localparam logic [ID_W-1:0] ID_WORD = make_idcode(ID_VERSION, ID_PART, ID_MFR);

    scan_ctl_t       ir_ctl;
    scan_ctl_t       bs_ctl;
    logic [IR_W-1:0] ir_code;
    logic            ir_so;
    dr_sel_e         dr_sel;
    logic            id_so, bs_so, rst_so, byp_so, dr_so;

    assign ir_ctl = '{capture: cap_ir, shift: shift_ir, update: upd_ir};
    assign dr_sel = decode_instr(ir_code);
    assign bs_ctl = '{capture: cap_dr   && (dr_sel == DR_BOUNDARY),
                      shift:   shift_dr && (dr_sel == DR_BOUNDARY),
                      update:  upd_dr   && (dr_sel == DR_BOUNDARY)};

    jtag_ir_unit u_ir (
        .tck(tck), .tlr(tlr), .tdi(tdi), .ctl(ir_ctl),
        .ir_so(ir_so), .ir_code(ir_code)
    );

    jtag_pload_sr #(.W(ID_W)) u_id (
        .tck(tck), .tlr(tlr), .tdi(tdi),
        .load(cap_dr && (dr_sel == DR_ID)),
        .shift(shift_dr && (dr_sel == DR_ID)),
        .pdata(ID_WORD), .so(id_so)
    );

    jtag_pload_sr #(.W(1)) u_byp (
        .tck(tck), .tlr(tlr), .tdi(tdi),
        .load(cap_dr && (dr_sel == DR_BYPASS)),
        .shift(shift_dr && (dr_sel == DR_BYPASS)),
        .pdata(1'b0), .so(byp_so)
    );

    // Reset cell: shift only, no capture, no update stage.
    jtag_pload_sr #(.W(1)) u_rst (
        .tck(tck), .tlr(tlr), .tdi(tdi),
        .load(1'b0),
        .shift(shift_dr && (dr_sel == DR_RSTCELL)),
        .pdata(1'b0), .so(rst_so)
    );

    jtag_bscan_chain #(.N(BSR_LEN)) u_bs (
        .tck(tck), .tlr(tlr), .tdi(tdi), .ctl(bs_ctl),
        .pin_in(pin_in), .chain_so(bs_so), .latch_q(bsr_latch)
    );

    always_comb begin
        case (dr_sel)
            DR_ID:       dr_so = id_so;
            DR_BOUNDARY: dr_so = bs_so;
            DR_RSTCELL:  dr_so = rst_so;
            default:     dr_so = byp_so;
        endcase
    end

    always_ff @(negedge tck) begin
        if (tlr)
            tdo <= 1'b0;
        else if (shift_ir)
            tdo <= ir_so;
        else if (shift_dr)
            tdo <= dr_so;
        else
            tdo <= 1'b0;
    end

    assign sys_rst_req = rst_so;

endmodule

// File: rtl/jtag_dr_unit_chk.sv
module jtag_dr_unit_chk #(
    parameter int N = 8
) (
    input logic         tck,
    input logic         tlr,
    input logic         shift_dr,
    input logic         upd_ir,
    input logic         upd_dr,
    input logic         tdi,
    input logic         sys_rst_req,
    input logic [N-1:0] bsr_latch,
    input logic [3:0]   ir_code
);

    logic seen_reset = 1'b0;
    always_ff @(posedge tck) if (tlr) seen_reset <= 1'b1;

    // R1
    assert_ir_default_R1: assert property (@(posedge tck)
        tlr |=> ir_code == 4'h1);

    // R4
    assert_ir_hold_R4: assert property (@(posedge tck) disable iff (tlr || !seen_reset)
        !upd_ir |=> $stable(ir_code));

    // R7
    assert_latch_hold_R7: assert property (@(posedge tck) disable iff (tlr || !seen_reset)
        !(upd_dr && ir_code == 4'h2) |=> $stable(bsr_latch));

    // R8
    assert_rst_direct_R8: assert property (@(posedge tck) disable iff (tlr || !seen_reset)
        (shift_dr && ir_code == 4'hC) |=> sys_rst_req == $past(tdi));

    // R9
    assert_rst_keep_R9: assert property (@(posedge tck) disable iff (tlr || !seen_reset)
        !(shift_dr && ir_code == 4'hC) |=> $stable(sys_rst_req));

    // R10
    assert_rst_clear_R10: assert property (@(posedge tck)
        tlr |=> !sys_rst_req);

endmodule

bind jtag_dr_unit jtag_dr_unit_chk #(.N(BSR_LEN)) u_chk (
    .tck(tck), .tlr(tlr), .shift_dr(shift_dr), .upd_ir(upd_ir), .upd_dr(upd_dr),
    .tdi(tdi), .sys_rst_req(sys_rst_req), .bsr_latch(bsr_latch), .ir_code(ir_code)
);

// File: tb/jtag_dr_unit_tb_top.sv
`timescale 1ns/1ps
module jtag_dr_unit_tb_top;

    localparam int N = 8;
    localparam logic [31:0] IDC = {4'h3, 16'h5A3C, 11'h2B5, 1'b1};

    logic tck = 1'b0;
    logic tlr = 1'b1, cap_ir = 0, shift_ir = 0, upd_ir = 0;
    logic cap_dr = 0, shift_dr = 0, upd_dr = 0, tdi = 0;
    logic [N-1:0] pin_in = '0;
    logic tdo, sys_rst_req;
    logic [N-1:0] bsr_latch;

    always #2 tck = ~tck;

    jtag_dr_unit #(.BSR_LEN(N), .ID_VERSION(4'h3), .ID_PART(16'h5A3C), .ID_MFR(11'h2B5)) dut_i (
        .tck(tck), .tlr(tlr), .cap_ir(cap_ir), .shift_ir(shift_ir), .upd_ir(upd_ir),
        .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr), .tdi(tdi),
        .pin_in(pin_in), .tdo(tdo), .sys_rst_req(sys_rst_req), .bsr_latch(bsr_latch)
    );

    int n_chk = 0, n_fail = 0;
    logic last_tdo;

    // Behavioural model: queues whose front is the bit nearest TDO.
    int m_ir = 1;
    bit m_irq[$];
    bit m_id[$];
    bit m_bs[$];
    bit m_latch[N];
    bit m_rst = 0, m_byp = 0;

    function automatic int m_sel(int c);
        if (c == 1) return 0;
        if (c == 2) return 1;
        if (c == 12) return 2;
        return 3;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(bit t, bit ci, bit si, bit ui, bit cd, bit sd, bit ud, bit d);
        bit exp_tdo;
        bit old_ir[$];
        logic [N-1:0] lv;
        int s;
        tlr = t; cap_ir = ci; shift_ir = si; upd_ir = ui;
        cap_dr = cd; shift_dr = sd; upd_dr = ud; tdi = d;
        s = m_sel(m_ir);
        exp_tdo = 0;
        if (!t) begin
            if (si) exp_tdo = m_irq[0];
            else if (sd) begin
                case (s)
                    0: exp_tdo = m_id[0];
                    1: exp_tdo = m_bs[0];
                    2: exp_tdo = m_rst;
                    default: exp_tdo = m_byp;
                endcase
            end
        end
        #2;
        last_tdo = tdo;
        for (int i = 0; i < N; i++) lv[i] = m_latch[i];
        chk(tdo === exp_tdo, "R3", 64'(tdo), 64'(exp_tdo));
        chk(sys_rst_req === m_rst, "R8", 64'(sys_rst_req), 64'(m_rst));
        chk(bsr_latch === lv, "R7", 64'(bsr_latch), 64'(lv));
        // model update for the coming rising edge
        if (t) begin
            m_ir = 1; m_irq = '{1, 0, 0, 0};
            m_id.delete(); m_bs.delete();
            for (int i = 0; i < 32; i++) m_id.push_back(0);
            for (int i = 0; i < N; i++) begin m_bs.push_back(0); m_latch[i] = 0; end
            m_rst = 0; m_byp = 0;
        end else begin
            old_ir = m_irq;
            if (ci) m_irq = '{1, 0, 0, 0};
            else if (si) begin m_irq.push_back(d); void'(m_irq.pop_front()); end
            if (ui) begin
                m_ir = 0;
                for (int i = 0; i < 4; i++) m_ir += int'(old_ir[i]) << i;
            end
            if (ud && s == 1)
                for (int i = 0; i < N; i++) m_latch[i] = m_bs[i];
            if (cd) begin
                case (s)
                    0: begin m_id.delete(); for (int i = 0; i < 32; i++) m_id.push_back(IDC[i]); end
                    1: begin m_bs.delete(); for (int i = 0; i < N; i++) m_bs.push_back(pin_in[i]); end
                    3: m_byp = 0;
                    default: ;
                endcase
            end else if (sd) begin
                case (s)
                    0: begin m_id.push_back(d); void'(m_id.pop_front()); end
                    1: begin m_bs.push_back(d); void'(m_bs.pop_front()); end
                    2: m_rst = d;
                    default: m_byp = d;
                endcase
            end
        end
        #2;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic reset_tap();
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic load_ir(logic [3:0] code, bit do_upd);
        logic [3:0] cap;
        step(0, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 1, 0, 0, 0, 0, code[i]);
            cap[i] = last_tdo;
        end
        chk(cap === 4'b0001, "R4", 64'(cap), 64'h1);
        if (do_upd) step(0, 0, 0, 1, 0, 0, 0, 0);
        idle();
    endtask

    task automatic scan_dr(int n, logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        step(0, 0, 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 0, 0, 0, 1, 0, din[i]);
            dout[i] = last_tdo;
        end
    endtask

    logic [63:0] dout;

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(posedge tck); #1;
        // R1: reset state
        reset_tap();
        chk(sys_rst_req === 0, "R1", 64'(sys_rst_req), 0);
        chk(bsr_latch === '0, "R1", 64'(bsr_latch), 0);
        idle();
        chk(last_tdo === 0, "R1", 64'(last_tdo), 0);
        // R2: default instruction is identification, word shifts out LSB first
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] === IDC, "R2", dout, 64'(IDC));
        idle();
        chk(last_tdo === 0, "R3", 64'(last_tdo), 0);
        // R5: bypass 4'hF
        load_ir(4'hF, 1);
        scan_dr(6, 64'b101101, dout);
        chk(dout[5:0] === 6'b011010, "R5", dout, 64'b011010);
        // R4: shift without update keeps bypass selected
        load_ir(4'h1, 0);
        scan_dr(3, 64'b111, dout);
        chk(dout[2:0] === 3'b110, "R4", dout, 64'b110);
        idle();
        // R6/R7: sample and preload
        load_ir(4'h2, 1);
        pin_in = 8'hA6;
        scan_dr(8, 64'h3C, dout);
        chk(dout[7:0] === 8'hA6, "R6", dout, 64'hA6);
        idle();
        chk(bsr_latch === 8'h00, "R7", 64'(bsr_latch), 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        chk(bsr_latch === 8'h3C, "R6", 64'(bsr_latch), 64'h3C);
        load_ir(4'h1, 1);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        chk(bsr_latch === 8'h3C, "R7", 64'(bsr_latch), 64'h3C);
        // R8: reset cell
        load_ir(4'hC, 1);
        scan_dr(1, 64'h1, dout);
        chk(sys_rst_req === 1, "R8", 64'(sys_rst_req), 1);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        chk(sys_rst_req === 1, "R8", 64'(sys_rst_req), 1);
        // R9: other instructions leave the request in place
        load_ir(4'h1, 1);
        chk(sys_rst_req === 1, "R9", 64'(sys_rst_req), 1);
        scan_dr(32, 64'hFFFF_FFFF, dout);
        chk(dout[31:0] === IDC, "R9", dout, 64'(IDC));
        chk(sys_rst_req === 1, "R9", 64'(sys_rst_req), 1);
        load_ir(4'hC, 1);
        scan_dr(1, 64'h0, dout);
        chk(dout[0] === 1'b1, "R8", dout, 1);
        chk(sys_rst_req === 0, "R8", 64'(sys_rst_req), 0);
        scan_dr(1, 64'h1, dout);
        chk(sys_rst_req === 1, "R8", 64'(sys_rst_req), 1);
        // R10: Test-Logic-Reset releases the request
        reset_tap();
        chk(sys_rst_req === 0, "R10", 64'(sys_rst_req), 0);
        chk(bsr_latch === '0, "R1", 64'(bsr_latch), 0);
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] === IDC, "R1", dout, 64'(IDC));
        // R11: unlisted codes behave as bypass
        load_ir(4'h5, 1);
        scan_dr(4, 64'b1011, dout);
        chk(dout[3:0] === 4'b0110, "R11", dout, 64'b0110);
        load_ir(4'h0, 1);
        scan_dr(3, 64'b001, dout);
        chk(dout[2:0] === 3'b010, "R11", dout, 64'b010);
        idle();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule